// File: doc/BRIEF.md
# Register-Style Readout Sequencer for a Serial Flash Slave

This block drives the serial data output of a serial flash slave for reads that return register-like values rather than array data. A command front end decodes the opcode and counts received bytes. It passes this block the opcode, the number of whole bytes received since chip select fell, and bit 0 of the last address byte. Once the header for a recognised opcode is complete, the block picks the byte to return and sends it most significant bit first. It repeats or rotates bytes in a pattern that depends on the command until chip select is released.

The serial clock is not used as a clock here. The front end supplies a one-cycle strobe for each falling serial-clock edge, and every output change is a register update on that strobe. The host can therefore sample each bit on the following rising serial edge. The status byte is an input. The identification values are parameters.

Top module: `reg_readout_seq`

## Requirements
- R1: While `cs_n` is high, and during reset, `so_oe` is 0. A rise of `cs_n` at any bit ends the output one clock later, and the next frame starts again from its first byte.
- R2: `so_oe` stays 0 until the first `sck_fall` strobe at which `hdr_bytes` equals the header length of the command. That length is 1 for 05h and 9Fh and 4 for ABh and 90h. Any other opcode never drives the output.
- R3: For opcode 05h, the status byte is returned repeatedly. `status_in` is captured on the strobe that emits bit 7 of each byte, so a change later in that byte appears only from the next byte on.
- R4: For opcode ABh, the `DEV_ID` parameter is returned repeatedly.
- R5: For opcode 90h with `addr_lsb` = 0, the bytes alternate `MFR_ID`, `DEV_ID`, `MFR_ID`, and so on.
- R6: For opcode 90h with `addr_lsb` = 1, the bytes alternate `DEV_ID`, `MFR_ID`, `DEV_ID`, and so on. Only bit 0 of the address byte matters.
- R7: For opcode 9Fh, the bytes run `MFR_ID`, `XID_HI`, `XID_LO` and then wrap to `MFR_ID`.
- R8: Every byte is sent most significant bit first. `so_data` changes only in the clock after an `sck_fall` strobe and holds its value in every other cycle while `cs_n` is low.
- R9: If `cs_n` is high in the same cycle as an `sck_fall` strobe, the deselect wins: `so_oe` and `so_data` are both 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sck_fall | input | 1 | One-cycle strobe for each falling serial-clock edge |
| cmd_code | input | 8 | Opcode of the current frame |
| hdr_bytes | input | CNT_W | Whole bytes received since `cs_n` fell |
| addr_lsb | input | 1 | Bit 0 of the 90h address byte |
| status_in | input | 8 | Current status register value |
| so_data | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for the serial data pad |

## Verification
Two events can fall in the same clock. The first pair is the capture of a new byte and an update of `status_in`. The bench changes the status value on the very strobe that emits bit 7 and expects the new value for the whole byte. It changes the value again a few bits into a byte and expects the old byte to finish untouched. The second pair is a deselect and a serial-clock strobe: the bench asserts `cs_n` together with `sck_fall` and expects the pad released and the data low one cycle later, with no bit emitted.

// File: rtl/rdo_pkg.sv
// Shared opcodes and readout mode type for the register readout sequencer.
// Assumes 8-bit opcodes as delivered by the command front end.
package rdo_pkg;
    localparam logic [7:0] OP_STATUS    = 8'h05;
    localparam logic [7:0] OP_LEGACY_ID = 8'hAB;
    localparam logic [7:0] OP_PAIR_ID   = 8'h90;
    localparam logic [7:0] OP_TRIPLE_ID = 8'h9F;

    typedef enum logic [2:0] {
        RM_NONE,
        RM_STATUS,
        RM_LEGACY,
        RM_PAIR,
        RM_TRIPLE
    } rd_mode_e;
endpackage

// File: rtl/rdo_cmd_decode.sv
// Maps an opcode to a readout mode, the header length in bytes that must
// precede output, and the index of the last byte in the repeating pattern.
// Assumes the opcode is stable for the whole frame.
module rdo_cmd_decode
    import rdo_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int SEQ_W = 2
) (
    input  logic [7:0]       cmd_code,
    output rd_mode_e         mode,
    output logic [CNT_W-1:0] hdr_need,
    output logic [SEQ_W-1:0] seq_last
);
    // Purpose: table lookup of mode, header length and pattern length.
    always_comb begin
        mode     = RM_NONE;
        hdr_need = '0;
        seq_last = '0;
        case (cmd_code)
            OP_STATUS: begin
                mode     = RM_STATUS;
                hdr_need = CNT_W'(1);
            end
            OP_LEGACY_ID: begin
                mode     = RM_LEGACY;
                hdr_need = CNT_W'(4);
            end
            OP_PAIR_ID: begin
                mode     = RM_PAIR;
                hdr_need = CNT_W'(4);
                seq_last = SEQ_W'(1);
            end
            OP_TRIPLE_ID: begin
                mode     = RM_TRIPLE;
                hdr_need = CNT_W'(1);
                seq_last = SEQ_W'(2);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rdo_byte_pick.sv
// Selects the byte to send for the current pattern position.
// Assumes seq never exceeds the pattern's last index from the decoder.
module rdo_byte_pick
    import rdo_pkg::*;
#(
    parameter int          BYTE_W = 8,
    parameter int          SEQ_W  = 2,
    parameter logic [BYTE_W-1:0] MFR_ID = 8'h1C,
    parameter logic [BYTE_W-1:0] DEV_ID = 8'h10,
    parameter logic [BYTE_W-1:0] XID_HI = 8'h20,
    parameter logic [BYTE_W-1:0] XID_LO = 8'h11
) (
    input  rd_mode_e          mode,
    input  logic [SEQ_W-1:0]  seq,
    input  logic              start_sel,
    input  logic [BYTE_W-1:0] status_in,
    output logic [BYTE_W-1:0] pick
);
    // Purpose: choose status, legacy ID, alternating pair or triple byte.
    always_comb begin
        pick = '0;
        case (mode)
            RM_STATUS: pick = status_in;
            RM_LEGACY: pick = DEV_ID;
            RM_PAIR:   pick = (seq[0] ^ start_sel) ? DEV_ID : MFR_ID;
            RM_TRIPLE: begin
                if (seq == SEQ_W'(0))      pick = MFR_ID;
                else if (seq == SEQ_W'(1)) pick = XID_HI;
                else                       pick = XID_LO;
            end
            default:   pick = '0;
        endcase
    end
endmodule

// File: rtl/rdo_bit_shift.sv
// Serialiser: on each falling serial-clock strobe emits the next bit MSB
// first, loading a fresh byte when the bit pointer is at the top, and
// advancing the pattern index after bit 0. Chip select high clears all.
// Assumes sck_fall is a single-cycle strobe in the clk domain.
module rdo_bit_shift #(
    parameter int BYTE_W = 8,
    parameter int SEQ_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_fall,
    input  logic              start_ok,
    input  logic [SEQ_W-1:0]  seq_last,
    input  logic [BYTE_W-1:0] cur_byte,
    output logic [SEQ_W-1:0]  seq,
    output logic              so_data,
    output logic              so_oe
);
    localparam int              BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] TOP  = BIT_W'(BYTE_W - 1);

    logic [BIT_W-1:0]  nbit;
    logic [BYTE_W-1:0] shreg;
    logic              step;

    // Purpose: a strobe advances the output once started or when ready to start.
    always_comb step = sck_fall && (so_oe || start_ok);

    // Purpose: bit pointer, pattern index, held byte and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            nbit    <= TOP;
            seq     <= '0;
            shreg   <= '0;
            so_data <= 1'b0;
            so_oe   <= 1'b0;
        end else if (step) begin
            so_oe <= 1'b1;
            if (nbit == TOP) begin
                shreg   <= cur_byte;
                so_data <= cur_byte[BYTE_W-1];
            end else begin
                so_data <= shreg[nbit];
            end
            if (nbit == '0) begin
                nbit <= TOP;
                seq  <= (seq == seq_last) ? '0 : seq + SEQ_W'(1);
            end else begin
                nbit <= nbit - BIT_W'(1);
            end
        end
    end
endmodule

// File: rtl/reg_readout_seq.sv
// Top of the register-style readout sequencer. Decodes the opcode, waits
// for the header byte count, then serialises status or ID bytes in the
// command's repeating pattern until chip select rises.
// Assumes hdr_bytes counts whole bytes since cs_n fell.
module reg_readout_seq
    import rdo_pkg::*;
#(
    parameter int         CNT_W  = 3,
    parameter logic [7:0] MFR_ID = 8'h1C,
    parameter logic [7:0] DEV_ID = 8'h10,
    parameter logic [7:0] XID_HI = 8'h20,
    parameter logic [7:0] XID_LO = 8'h11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck_fall,
    input  logic [7:0]       cmd_code,
    input  logic [CNT_W-1:0] hdr_bytes,
    input  logic             addr_lsb,
    input  logic [7:0]       status_in,
    output logic             so_data,
    output logic             so_oe
);
    localparam int BYTE_W = 8;
    localparam int SEQ_W  = 2;

    rd_mode_e          mode;
    logic [CNT_W-1:0]  hdr_need;
    logic [SEQ_W-1:0]  seq_last;
    logic [SEQ_W-1:0]  seq;
    logic [BYTE_W-1:0] cur_byte;
    logic              start_ok;

    rdo_cmd_decode #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) dec_i (
        .cmd_code (cmd_code),
        .mode     (mode),
        .hdr_need (hdr_need),
        .seq_last (seq_last)
    );

    // Purpose: header complete for a recognised command.
    always_comb start_ok = (mode != RM_NONE) && (hdr_bytes == hdr_need);

    rdo_byte_pick #(
        .BYTE_W(BYTE_W), .SEQ_W(SEQ_W),
        .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .XID_HI(XID_HI), .XID_LO(XID_LO)
    ) pick_i (
        .mode      (mode),
        .seq       (seq),
        .start_sel (addr_lsb),
        .status_in (status_in),
        .pick      (cur_byte)
    );

    rdo_bit_shift #(.BYTE_W(BYTE_W), .SEQ_W(SEQ_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck_fall (sck_fall),
        .start_ok (start_ok),
        .seq_last (seq_last),
        .cur_byte (cur_byte),
        .seq      (seq),
        .so_data  (so_data),
        .so_oe    (so_oe)
    );
endmodule

// File: rtl/reg_readout_seq_chk.sv
// Port-level protocol checks for reg_readout_seq, attached by bind.
module reg_readout_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck_fall,
    input logic so_data,
    input logic so_oe
);
    // R1: deselect releases the pad on the next cycle
    assert_release_on_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe);

    // R2: the pad can only become driven on a falling-edge strobe
    assert_start_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!so_oe && !sck_fall) |=> !so_oe);

    // R8: without a strobe the data bit and enable hold
    assert_hold_between_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sck_fall) |=> ($stable(so_data) && $stable(so_oe)));

    // R9: deselect beats a simultaneous strobe
    assert_deselect_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && sck_fall) |=> (!so_oe && !so_data));
endmodule

bind reg_readout_seq reg_readout_seq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck_fall (sck_fall),
    .so_data  (so_data),
    .so_oe    (so_oe)
);

// File: tb/reg_readout_seq_tb_top.sv
module reg_readout_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic       sck_fall;
    logic [7:0] cmd_code;
    logic [2:0] hdr_bytes;
    logic       addr_lsb;
    logic [7:0] status_in;
    logic       so_data;
    logic       so_oe;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    reg_readout_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall),
        .cmd_code(cmd_code), .hdr_bytes(hdr_bytes), .addr_lsb(addr_lsb),
        .status_in(status_in), .so_data(so_data), .so_oe(so_oe)
    );

    // Vector: cmd, lsb, status, six expected bytes.
    localparam int NV = 6;
    localparam logic [64:0] VEC [NV] = '{
        {8'h05, 1'b0, 8'hA5, 48'hA5A5A5A5A5A5},
        {8'hAB, 1'b0, 8'h00, 48'h101010101010},
        {8'h90, 1'b0, 8'h00, 48'h1C101C101C10},
        {8'h90, 1'b1, 8'h00, 48'h101C101C101C},
        {8'h9F, 1'b0, 8'h00, 48'h1C20111C2011},
        {8'h05, 1'b1, 8'h3C, 48'h3C3C3C3C3C3C}
    };

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] chg, input bit do_chg);
        @(negedge clk);
        sck_fall = 1'b1;
        if (do_chg) status_in = chg;
        @(negedge clk);
        sck_fall = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b, input int chg_at, input logic [7:0] chg_val);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            logic first;
            pulse(chg_val, i == chg_at);
            first = so_data;
            b = {b[6:0], so_data};
            @(negedge clk);
            check(so_data == first && so_oe, "R8", {7'd0, so_data}, {7'd0, first});
        end
    endtask

    function automatic logic [2:0] need_of(input logic [7:0] c);
        return (c == 8'h05 || c == 8'h9F) ? 3'd1 : 3'd4;
    endfunction

    function automatic string tag_of(input logic [7:0] c, input logic l);
        case (c)
            8'h05: return "R3";
            8'hAB: return "R4";
            8'h90: return l ? "R6" : "R5";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #1ms;
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        rst_n = 1'b0; cs_n = 1'b1; sck_fall = 1'b0; cmd_code = '0;
        hdr_bytes = '0; addr_lsb = 1'b0; status_in = '0;
        repeat (3) @(negedge clk);
        check(!so_oe && !so_data, "R1", {6'd0, so_oe, so_data}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check(!so_oe, "R1", {7'd0, so_oe}, 8'h00);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] c;
            logic [47:0] exp;
            c = VEC[v][64:57];
            exp = VEC[v][47:0];
            cmd_code = c; addr_lsb = VEC[v][56]; status_in = VEC[v][55:48];
            cs_n = 1'b0;
            hdr_bytes = need_of(c) - 3'd1;
            pulse(8'h00, 0);
            check(!so_oe, "R2", {7'd0, so_oe}, 8'h00);
            hdr_bytes = need_of(c);
            for (int k = 0; k < 6; k++) begin
                read_byte(b, -1, 8'h00);
                check(b == exp[47-8*k -: 8], tag_of(c, addr_lsb), b, exp[47-8*k -: 8]);
            end
            @(negedge clk);
            cs_n = 1'b1; hdr_bytes = '0;
            @(negedge clk);
            check(!so_oe, "R1", {7'd0, so_oe}, 8'h00);
        end

        // R2: unrecognised opcode never drives
        cs_n = 1'b0; cmd_code = 8'h03; hdr_bytes = 3'd4;
        repeat (10) pulse(8'h00, 0);
        check(!so_oe, "R2", {7'd0, so_oe}, 8'h00);
        cs_n = 1'b1; @(negedge clk);

        // R1: release mid-byte, restart from first byte
        cs_n = 1'b0; cmd_code = 8'h9F; hdr_bytes = 3'd1;
        read_byte(b, -1, 8'h00);
        repeat (3) pulse(8'h00, 0);
        cs_n = 1'b1;
        @(negedge clk);
        check(!so_oe, "R1", {7'd0, so_oe}, 8'h00);
        cs_n = 1'b0;
        read_byte(b, -1, 8'h00);
        check(b == 8'h1C, "R1", b, 8'h1C);
        read_byte(b, -1, 8'h00);
        check(b == 8'h20, "R7", b, 8'h20);

        // R9: deselect in the same cycle as a strobe
        read_byte(b, -1, 8'h00);
        @(negedge clk);
        sck_fall = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        sck_fall = 1'b0;
        check(!so_oe && !so_data, "R9", {6'd0, so_oe, so_data}, 8'h00);

        // R3: status capture at byte start vs later change
        cs_n = 1'b0; cmd_code = 8'h05; hdr_bytes = 3'd1; status_in = 8'hA5;
        read_byte(b, 3, 8'h3C);
        check(b == 8'hA5, "R3", b, 8'hA5);
        read_byte(b, 0, 8'h5A);
        check(b == 8'h5A, "R3", b, 8'h5A);
        cs_n = 1'b1; @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule